// File: doc/BRIEF.md
# Two-Stage Bus Watchdog Timer

This block is a 32-bit down-counting watchdog that sits on a simple single-cycle register bus. Software sets a reload interval, turns on the interrupt and reset enables, and then writes the clear register at regular intervals to restart the count. If the count runs out once, the block raises an interrupt and starts counting again. If it runs out a second time while that interrupt is still pending, and reset is enabled, the block asserts a watchdog reset towards the system reset controller and freezes.

The counter moves only on cycles where the tick input is high, which is the divided count clock qualified as an enable. It also holds while the low-power stop input is asserted. A key-protected lock guards the writable registers against stray writes. Reads are allowed at all times.

Register offsets, in bus words: 0 reload interval, 1 current count (read only), 2 control, 3 interrupt clear (write only), 4 raw status (read only), 5 lock.

Top module: `wdog_top`

## Requirements
- R1: After rst_ni is released, the reload register and the count both read 0xFFFFFFFF, control reads 0, the lock register reads 1 (locked), and irq_o and wdog_rst_o are low.
- R2: Writing 0x1ACCE551 to offset 5 unlocks the block. Writing any other value there locks it. Offset 5 reads 1 in bit 0 while locked and 0 while unlocked.
- R3: While the block is locked, writes to offsets 0, 2 and 3 have no effect. Reads of every offset work whether the block is locked or not.
- R4: In control, bit 0 is interrupt enable and bit 1 is reset enable. Bits 31:2 always read 0, and writes to them are ignored.
- R5: On each cycle with tick_i high, interrupt enable set, stop_i low and no watchdog reset active, the count drops by one. While interrupt enable is 0, the count holds.
- R6: A counting tick that arrives while the count is 0 is an underflow. It sets the interrupt flag and reloads the count from the reload register.
- R7: An underflow that arrives while the flag is already set and reset enable is 1 raises wdog_rst_o. wdog_rst_o then stays high and the count stays frozen until rst_ni. Without reset enable, such an underflow only reloads the count.
- R8: A write of any value to offset 3 clears the interrupt flag and reloads the count from the reload register.
- R9: A write to offset 0 stores the new interval and loads it into the count at the same clock edge. With an interval of 0, the next counting tick underflows.
- R10: While stop_i is high, the count holds its value. Counting resumes from that value when stop_i falls.
- R11: Offset 4 returns the interrupt flag in bit 0 whatever the enables are set to. irq_o is the flag ANDed with interrupt enable.
- R12: A read of an offset outside 0 to 5, or of offset 3, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable pulse from the clock divider |
| stop_i | input | 1 | Low-power stop; holds the count |
| wr_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| wdog_rst_o | output | 1 | Watchdog reset request, sticky until rst_ni |

## Verification
The assertions assume that a write strobe lasts one cycle and that addr_i and wdata_i are stable while it is high. They also assume that tick_i is a plain enable sampled at the clock edge, not a clock. The stop-hold and lock checks take for granted that no reload write lands in the same cycle. The bench drives every input on the falling edge, raises tick_i for one cycle at a time, and never overlaps a write with a tick. This keeps the cycles in which underflow, reload and clear happen free of any ambiguity about which comes first.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_LOAD   = 0;
  localparam int unsigned OFS_VALUE  = 1;
  localparam int unsigned OFS_CTRL   = 2;
  localparam int unsigned OFS_CLEAR  = 3;
  localparam int unsigned OFS_STATUS = 4;
  localparam int unsigned OFS_LOCK   = 5;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned       DW        = 32,
  parameter int unsigned       AW        = 3,
  parameter logic [DW-1:0]     KEY       = 32'h1ACC_E551,
  parameter logic [DW-1:0]     LOAD_INIT = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] load_o,
  output wdog_ctrl_t    ctrl_o,
  output logic          locked_o,
  output logic          reload_o,
  output logic [DW-1:0] reload_val_o,
  output logic          clear_o
);
  logic          locked_q;
  logic [DW-1:0] load_q;
  wdog_ctrl_t    ctrl_q;
  logic          hit_load, hit_ctrl, hit_clear, hit_lock, wr_ok;

  assign hit_load  = addr_i == AW'(OFS_LOAD);
  assign hit_ctrl  = addr_i == AW'(OFS_CTRL);
  assign hit_clear = addr_i == AW'(OFS_CLEAR);
  assign hit_lock  = addr_i == AW'(OFS_LOCK);
  assign wr_ok     = wr_i & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      load_q   <= LOAD_INIT;
      ctrl_q   <= '0;
    end else begin
      if (wr_i && hit_lock) locked_q <= (wdata_i != KEY);
      if (wr_ok && hit_load) load_q <= wdata_i;
      if (wr_ok && hit_ctrl) ctrl_q <= wdog_ctrl_t'(wdata_i[1:0]);
    end
  end

  assign load_o       = load_q;
  assign ctrl_o       = ctrl_q;
  assign locked_o     = locked_q;
  assign reload_o     = wr_ok & (hit_load | hit_clear);
  assign reload_val_o = hit_load ? wdata_i : load_q;
  assign clear_o      = wr_ok & hit_clear;

  // R3
  lock_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && locked_q && hit_load) |=> $stable(load_q));
  // R3
  lock_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && locked_q && hit_ctrl) |=> $stable(ctrl_q));
  // R2
  key_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_lock && wdata_i == KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned   DW        = 32,
  parameter logic [DW-1:0] LOAD_INIT = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stop_i,
  input  wdog_ctrl_t    ctrl_i,
  input  logic [DW-1:0] load_i,
  input  logic          reload_i,
  input  logic [DW-1:0] reload_val_i,
  input  logic          clear_i,
  output logic [DW-1:0] count_o,
  output logic          flag_o,
  output logic          bite_o
);
  logic [DW-1:0] count_q;
  logic          flag_q, bite_q, run, uflow;

  assign run   = tick_i & ~stop_i & ctrl_i.irq_en & ~bite_q;
  // a bus reload in the same cycle wins over the underflow
  assign uflow = run & (count_q == '0) & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= LOAD_INIT;
      flag_q  <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      if (reload_i && !bite_q)           count_q <= reload_val_i;
      else if (uflow) begin
        if (flag_q && ctrl_i.rst_en)     bite_q  <= 1'b1;
        else                             count_q <= load_i;
      end else if (run)                  count_q <= count_q - 1'b1;

      if (clear_i)      flag_q <= 1'b0;
      else if (uflow)   flag_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;
  assign bite_o  = bite_q;

  // R10
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !reload_i) |=> $stable(count_q));
  // R7
  bite_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bite_q) |-> $past(flag_q && ctrl_i.rst_en && tick_i));
  // R7
  bite_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_q |=> (bite_q && $stable(count_q)));
  // R6
  uflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && ctrl_i.irq_en && !bite_q && count_q == '0
     && !reload_i && !clear_i) |=> flag_q);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.irq_en && !reload_i) |=> $stable(count_q));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 3,
  parameter logic [DW-1:0] KEY       = 32'h1ACC_E551,
  parameter logic [DW-1:0] LOAD_INIT = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stop_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wdog_rst_o
);
  localparam int unsigned CTRL_W = $bits(wdog_ctrl_t);

  logic [DW-1:0] load, count, reload_val;
  wdog_ctrl_t    ctrl;
  logic          locked, reload, clear, flag, bite;

  wdog_regs #(.DW(DW), .AW(AW), .KEY(KEY), .LOAD_INIT(LOAD_INIT)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .load_o(load), .ctrl_o(ctrl), .locked_o(locked),
    .reload_o(reload), .reload_val_o(reload_val), .clear_o(clear)
  );

  wdog_count #(.DW(DW), .LOAD_INIT(LOAD_INIT)) u_count (
    .clk_i, .rst_ni, .tick_i, .stop_i, .ctrl_i(ctrl), .load_i(load),
    .reload_i(reload), .reload_val_i(reload_val), .clear_i(clear),
    .count_o(count), .flag_o(flag), .bite_o(bite)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFS_LOAD):   rdata_o = load;
      AW'(OFS_VALUE):  rdata_o = count;
      AW'(OFS_CTRL):   rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl};
      AW'(OFS_STATUS): rdata_o = {{(DW-1){1'b0}}, flag};
      AW'(OFS_LOCK):   rdata_o = {{(DW-1){1'b0}}, locked};
      default:         rdata_o = '0;
    endcase
  end

  assign irq_o      = flag & ctrl.irq_en;
  assign wdog_rst_o = bite;

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.irq_en) |-> !irq_o);
endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,        32'hFFFF_FFFF, 4'd1},  // R1 reload reset
    '{1'b0, 3'd1, 32'h0,        32'hFFFF_FFFF, 4'd1},  // R1 count reset
    '{1'b0, 3'd2, 32'h0,        32'h0,         4'd1},  // R1 control reset
    '{1'b0, 3'd5, 32'h0,        32'h1,         4'd1},  // R1 locked
    '{1'b1, 3'd0, 32'h5,        32'h0,         4'd3},  // R3 locked write
    '{1'b0, 3'd0, 32'h0,        32'hFFFF_FFFF, 4'd3},
    '{1'b1, 3'd5, KEY,          32'h0,         4'd2},  // R2 unlock
    '{1'b0, 3'd5, 32'h0,        32'h0,         4'd2},
    '{1'b1, 3'd0, 32'h10,       32'h0,         4'd9},  // R9
    '{1'b0, 3'd0, 32'h0,        32'h10,        4'd9},
    '{1'b0, 3'd1, 32'h0,        32'h10,        4'd9},
    '{1'b1, 3'd2, 32'hFFFF_FFFC, 32'h0,        4'd4},  // R4 reserved only
    '{1'b0, 3'd2, 32'h0,        32'h0,         4'd4},
    '{1'b1, 3'd5, 32'h1234,     32'h0,         4'd2},  // R2 relock
    '{1'b0, 3'd5, 32'h0,        32'h1,         4'd2},
    '{1'b0, 3'd6, 32'h0,        32'h0,         4'd12}, // R12 unmapped
    '{1'b0, 3'd3, 32'h0,        32'h0,         4'd12}  // R12 clear reads 0
  };

  logic        clk_i = 0, rst_ni = 0, tick_i = 0, stop_i = 0, wr_i = 0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, wdog_rst_o;
  int total = 0, bad = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdog_top u_wdog_top (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    addr_i = a; #1; chk(tag, rdata_o, exp);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1;
      @(negedge clk_i); tick_i = 0;
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 wdog_rst_o", {31'b0, wdog_rst_o}, 0);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        @(negedge clk_i);
        rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
      end
    end
    // R3 reads allowed while locked, counter untouched by locked clear
    wr(3'd3, 32'h0);
    rd("R3 locked read", 3'd1, 32'h10);

    wr(3'd5, KEY);
    wr(3'd2, 32'h1);
    wr(3'd0, 32'h3);
    rd("R9 load to count", 3'd1, 3);
    tick(1);
    rd("R5 decrement", 3'd1, 2);
    stop_i = 1;
    tick(2);
    rd("R10 stop hold", 3'd1, 2);
    stop_i = 0;
    tick(1);
    rd("R10 resume", 3'd1, 1);
    tick(1);
    rd("R5 reach zero", 3'd1, 0);
    chk("R6 no flag yet", {31'b0, irq_o}, 0);
    tick(1);
    rd("R6 reload", 3'd1, 3);
    rd("R6 status", 3'd4, 1);
    chk("R11 irq_o", {31'b0, irq_o}, 1);
    wr(3'd3, 32'hDEAD_BEEF);
    rd("R8 flag cleared", 3'd4, 0);
    rd("R8 reload", 3'd1, 3);
    chk("R8 irq_o low", {31'b0, irq_o}, 0);

    wr(3'd0, 32'h0);
    rd("R9 zero load", 3'd1, 0);
    tick(1);
    rd("R9 zero interval flags", 3'd4, 1);

    wr(3'd0, 32'h2);
    wr(3'd3, 32'h0);
    tick(3);
    rd("R6 flag again", 3'd4, 1);
    rd("R6 count", 3'd1, 2);
    wr(3'd2, 32'h0);
    chk("R11 irq gated", {31'b0, irq_o}, 0);
    rd("R11 raw status", 3'd4, 1);
    tick(2);
    rd("R5 hold when disabled", 3'd1, 2);

    wr(3'd2, 32'h1);
    tick(3);
    chk("R7 no reset without enable", {31'b0, wdog_rst_o}, 0);
    rd("R7 reload only", 3'd1, 2);
    wr(3'd2, 32'h3);
    rd("R4 control", 3'd2, 3);
    tick(3);
    chk("R7 reset asserted", {31'b0, wdog_rst_o}, 1);
    rd("R7 frozen", 3'd1, 0);
    tick(3);
    wr(3'd0, 32'h7);
    chk("R7 reset sticky", {31'b0, wdog_rst_o}, 1);
    rd("R7 still frozen", 3'd1, 0);

    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset clears bite", {31'b0, wdog_rst_o}, 0);
    rd("R1 count after reset", 3'd1, 32'hFFFF_FFFF);
    rd("R1 lock after reset", 3'd5, 1);

    done = 1;
    report();
  end
endmodule